// File: doc/BRIEF.md
# Two-group DMA channel arbiter

This block decides which of four DMA channels drives the system bus. The channels form two groups of two: indices 0 and 1 make up group 0, and indices 2 and 3 make up group 1. When a channel raises its request line, the block asks the bus master for the bus. When the grant comes back, it picks one channel and marks it active. It then follows that channel's transfer mode to decide when to hand the bus to another channel or back to the processor.

The transfer engine reports its progress through two inputs. `unit_done_i` marks the end of each byte or word. `block_end_i`, raised together with `unit_done_i`, marks the end of a whole burst or of one block. Each channel has a 2-bit mode code:
- Codes 00 (single address) and 01 (cycle steal) give up the bus after every unit.
- Codes 10 (burst) and 11 (block) keep the bus until the end mark.
- A group-1 channel in code 10 or 11 is also cut short at the next unit boundary if any group-0 channel is requesting.

When the bus goes back to the processor, the block inserts one dead cycle first.

Top module: `dmac_grp_arb`

## Requirements
- R1: After reset, `bus_req_o`, `active_o`, `start_o` and `dead_o` are all 0. With no request, `bus_req_o` stays 0.
- R2: While idle, a nonzero `req_i` raises `bus_req_o` one cycle later. No channel becomes active before `grant_i` is seen.
- R3: At the grant edge, the requesting channel with the lowest index becomes active in the next cycle. `active_o` is one-hot with bit i standing for channel i, and `start_o` is high for exactly that first cycle. Within a group, the A channel (lower index) beats the B channel.
- R4: If both groups request at the grant edge, a group-0 channel (index 0 or 1) wins over any group-1 channel (index 2 or 3).
- R5: While a channel is active and `unit_done_i` is low, requests on other channels do not change `active_o` and do not pulse `start_o`.
- R6: The mode of channel i is `mode_i[2*i+1:2*i]`. For codes 00 and 01, every `unit_done_i` releases the bus. The block then re-arbitrates over `req_i` at that edge, and the releasing channel may win again with a new `start_o`.
- R7: For codes 10 and 11, `unit_done_i` without `block_end_i` keeps the same owner with no `start_o`, unless R8 applies. `unit_done_i` with `block_end_i` releases the bus.
- R8: An active group-1 channel in code 10 or 11 releases the bus at the first `unit_done_i` that sees any group-0 request. The highest-priority group-0 requester becomes active in the next cycle.
- R9: On a release with another request pending, the new owner is active in the very next cycle. `bus_req_o` stays high and no dead cycle is inserted.
- R10: On a release with no request pending, the next cycle has `active_o` at 0, `bus_req_o` at 0 and `dead_o` at 1. `dead_o` is high for exactly one cycle.
- R11: A group-1 channel that was cut short keeps its request. It regains the bus through normal arbitration once group 0 releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Transfer request per channel, bit i = channel i |
| mode_i | input | 8 | Transfer mode per channel, 2 bits each |
| grant_i | input | 1 | Bus granted to the DMA side |
| unit_done_i | input | 1 | Current byte or word transfer finished |
| block_end_i | input | 1 | Burst or block finished, valid with unit_done_i |
| bus_req_o | output | 1 | Bus request to the bus master |
| active_o | output | 4 | One-hot owner channel |
| start_o | output | 1 | One-cycle pulse when a channel takes ownership |
| dead_o | output | 1 | Dead cycle before the bus returns to the processor |

## Verification
The properties assume a well-behaved environment:
- `grant_i` stays high for as long as a channel is active.
- `unit_done_i` arrives only while a channel owns the bus.
- `block_end_i` is raised only together with `unit_done_i`.
- The owner's mode code does not change during its ownership.

The bench keeps within these limits. It raises the grant only after it has seen `bus_req_o`, and it holds the grant until the final release. It pulses the unit handshakes only in cycles where it expects a channel to be active. It also changes `mode_i` only while the block is idle.

// File: rtl/dmac_arb_pkg.sv
package dmac_arb_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_STEAL  = 2'b01,
    MODE_BURST  = 2'b10,
    MODE_BLOCK  = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_OWN,
    ST_DEAD
  } arb_state_e;

  // modes that keep the bus across unit boundaries
  function automatic logic holds_bus(xfer_mode_e m);
    return (m == MODE_BURST) || (m == MODE_BLOCK);
  endfunction
endpackage

// File: rtl/dmac_prio_pick.sv
module dmac_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/dmac_mode_mux.sv
module dmac_mode_mux
  import dmac_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]   sel_i,
  input  logic [2*NCH-1:0] mode_i,
  output xfer_mode_e       mode_o
);
  logic [NCH-1:0][1:0] terms;

  for (genvar i = 0; i < NCH; i++) begin : g_term
    assign terms[i] = sel_i[i] ? mode_i[2*i +: 2] : 2'b00;
  end

  always_comb begin
    logic [1:0] acc;
    acc = 2'b00;
    for (int i = 0; i < NCH; i++) acc = acc | terms[i];
    mode_o = xfer_mode_e'(acc);
  end
endmodule

// File: rtl/dmac_release_ctl.sv
module dmac_release_ctl
  import dmac_arb_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CH_PER_GRP = 2
) (
  input  logic [NCH-1:0] active_i,
  input  xfer_mode_e     act_mode_i,
  input  logic [NCH-1:0] req_i,
  input  logic           unit_done_i,
  input  logic           block_end_i,
  output logic           release_o,
  output logic           preempt_o
);
  localparam logic [NCH-1:0] G0_MASK = NCH'((1 << CH_PER_GRP) - 1);

  logic owned, owner_g1, g0_req, holds;

  assign owned    = |active_i;
  assign owner_g1 = |(active_i & ~G0_MASK);
  assign g0_req   = |(req_i & G0_MASK);
  assign holds    = holds_bus(act_mode_i);

  assign preempt_o = owned & unit_done_i & owner_g1 & holds & g0_req;
  assign release_o = owned & unit_done_i & (~holds | block_end_i | preempt_o);
endmodule

// File: rtl/dmac_grp_arb.sv
module dmac_grp_arb
  import dmac_arb_pkg::*;
#(
  parameter int CH_PER_GRP = 2,
  parameter int N_GRP      = 2,
  parameter int NCH        = CH_PER_GRP * N_GRP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   req_i,
  input  logic [2*NCH-1:0] mode_i,
  input  logic             grant_i,
  input  logic             unit_done_i,
  input  logic             block_end_i,
  output logic             bus_req_o,
  output logic [NCH-1:0]   active_o,
  output logic             start_o,
  output logic             dead_o
);
  arb_state_e     state_q, state_d;
  logic [NCH-1:0] active_q, active_d;
  logic           start_q, start_d;

  logic [NCH-1:0] pick_gnt;
  logic           pick_any;
  xfer_mode_e     act_mode;
  logic           rel, preempt;

  dmac_prio_pick #(.N(NCH)) u_pick (
    .req_i (req_i),
    .gnt_o (pick_gnt),
    .any_o (pick_any)
  );

  dmac_mode_mux #(.NCH(NCH)) u_mux (
    .sel_i  (active_q),
    .mode_i (mode_i),
    .mode_o (act_mode)
  );

  dmac_release_ctl #(.NCH(NCH), .CH_PER_GRP(CH_PER_GRP)) u_rel (
    .active_i    (active_q),
    .act_mode_i  (act_mode),
    .req_i       (req_i),
    .unit_done_i (unit_done_i),
    .block_end_i (block_end_i),
    .release_o   (rel),
    .preempt_o   (preempt)
  );

  always_comb begin
    state_d  = state_q;
    active_d = active_q;
    start_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pick_any) state_d = ST_REQ;
      ST_REQ: begin
        if (!pick_any) begin
          state_d = ST_IDLE;
        end else if (grant_i) begin
          state_d  = ST_OWN;
          active_d = pick_gnt;
          start_d  = 1'b1;
        end
      end
      ST_OWN: begin
        if (rel) begin
          if (pick_any) begin
            // direct handover, bus kept
            active_d = pick_gnt;
            start_d  = 1'b1;
          end else begin
            active_d = '0;
            state_d  = ST_DEAD;
          end
        end
      end
      ST_DEAD: state_d = pick_any ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      active_q <= '0;
      start_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      active_q <= active_d;
      start_q  <= start_d;
    end
  end

  assign bus_req_o = (state_q == ST_REQ) || (state_q == ST_OWN);
  assign active_o  = active_q;
  assign start_o   = start_q;
  assign dead_o    = (state_q == ST_DEAD);
endmodule

// File: rtl/dmac_grp_arb_chk.sv
module dmac_grp_arb_chk #(
  parameter int CH_PER_GRP = 2,
  parameter int NCH        = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NCH-1:0]   req_i,
  input logic [2*NCH-1:0] mode_i,
  input logic             grant_i,
  input logic             unit_done_i,
  input logic             block_end_i,
  input logic             bus_req_o,
  input logic [NCH-1:0]   active_o,
  input logic             start_o,
  input logic             dead_o
);
  localparam logic [NCH-1:0] G0_MASK = NCH'((1 << CH_PER_GRP) - 1);

  logic [1:0] owner_mode;
  logic       owned, owner_g1, g0_req;

  always_comb begin
    owner_mode = 2'b00;
    for (int i = 0; i < NCH; i++)
      if (active_o[i]) owner_mode = mode_i[2*i +: 2];
  end

  assign owned    = |active_o;
  assign owner_g1 = |(active_o & ~G0_MASK);
  assign g0_req   = |(req_i & G0_MASK);

  p_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(active_o));

  p_owner_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owned |-> (bus_req_o && grant_i));

  p_start_owner_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> owned);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned && !unit_done_i) |=> ($stable(active_o) && !start_o));

  p_burst_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned && unit_done_i && !block_end_i && owner_mode[1] && !(owner_g1 && g0_req))
      |=> ($stable(active_o) && !start_o));

  p_preempt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned && unit_done_i && owner_g1 && owner_mode[1] && g0_req)
      |=> ((|(active_o & G0_MASK)) && start_o));

  p_single_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned && unit_done_i && !owner_mode[1] && req_i == '0)
      |=> (!owned && dead_o));

  p_dead_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> !dead_o);

  p_dead_no_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> (!bus_req_o && !owned));

  p_end_ok_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_end_i |-> unit_done_i);
endmodule

bind dmac_grp_arb dmac_grp_arb_chk #(.CH_PER_GRP(CH_PER_GRP), .NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .mode_i      (mode_i),
  .grant_i     (grant_i),
  .unit_done_i (unit_done_i),
  .block_end_i (block_end_i),
  .bus_req_o   (bus_req_o),
  .active_o    (active_o),
  .start_o     (start_o),
  .dead_o      (dead_o)
);

// File: tb/sim_dmac_grp_arb.sv
module sim_dmac_grp_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [7:0] mode_i = '0;
  logic       grant_i = 1'b0;
  logic       unit_done_i = 1'b0;
  logic       block_end_i = 1'b0;
  logic       bus_req_o;
  logic [3:0] active_o;
  logic       start_o;
  logic       dead_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dmac_grp_arb u0 (
    .clk_i, .rst_ni, .req_i, .mode_i, .grant_i, .unit_done_i, .block_end_i,
    .bus_req_o, .active_o, .start_o, .dead_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  function automatic logic [3:0] lowest(input logic [3:0] p);
    return p & (~p + 4'd1);
  endfunction

  // idle -> request -> grant -> owner; also checks R5 during ownership
  task automatic acquire(input logic [3:0] p);
    logic [3:0] e;
    e = lowest(p);
    req_i = p; grant_i = 1'b0;
    cyc();
    chk(bus_req_o === 1'b1, "R2 bus_req", bus_req_o, 1);
    chk(active_o === 4'h0, "R2 no owner before grant", active_o, 0);
    grant_i = 1'b1;
    cyc();
    chk(active_o === e, (p & 4'h3) != 0 && (p & 4'hC) != 0 ? "R4 group0 wins" : "R3 priority",
        active_o, e);
    chk(start_o === 1'b1, "R3 start", start_o, 1);
    req_i = 4'hF;
    cyc();
    chk(active_o === e && start_o === 1'b0, "R5 hold", {start_o, active_o}, e);
    req_i = p;
  endtask

  task automatic release_all();
    unit_done_i = 1'b1; block_end_i = 1'b1; req_i = '0;
    cyc();
    chk(active_o === 4'h0 && bus_req_o === 1'b0 && dead_o === 1'b1, "R10 dead",
        {dead_o, bus_req_o, active_o}, 6'h20);
    unit_done_i = 1'b0; block_end_i = 1'b0; grant_i = 1'b0;
    cyc();
    chk(dead_o === 1'b0 && bus_req_o === 1'b0, "R10 one dead cycle",
        {dead_o, bus_req_o}, 0);
  endtask

  initial begin
    repeat (3) cyc();
    chk(bus_req_o === 1'b0 && active_o === 4'h0 && start_o === 1'b0 && dead_o === 1'b0,
        "R1 reset", {bus_req_o, active_o, start_o, dead_o}, 0);
    rst_ni = 1'b1;
    repeat (2) cyc();
    chk(bus_req_o === 1'b0, "R1 quiet", bus_req_o, 0);

    // every request pattern
    for (int p = 1; p < 16; p++) begin
      mode_i = 8'h00;
      acquire(4'(p));
      release_all();
    end

    // every mode on every channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic [3:0] oh, nx;
        oh = 4'(1 << ch);
        nx = 4'(1 << ((ch + 1) % 4));
        mode_i = {4{2'(m)}};
        acquire(oh);
        unit_done_i = 1'b1; block_end_i = 1'b0; req_i = oh | 4'h8;
        cyc();
        chk(active_o === oh, m < 2 ? "R6 rearb" : "R7 keep", active_o, oh);
        chk(start_o === (m < 2), m < 2 ? "R6 restart" : "R7 no restart", start_o, m < 2);
        unit_done_i = 1'b1; block_end_i = 1'b1; req_i = nx;
        cyc();
        chk(active_o === nx && start_o === 1'b1 && bus_req_o === 1'b1 && dead_o === 1'b0,
            "R9 handover", {dead_o, bus_req_o, start_o, active_o}, {3'b011, nx});
        release_all();
      end
    end

    // group-1 owner cut short by group 0
    for (int ch = 2; ch < 4; ch++) begin
      for (int m = 0; m < 4; m++) begin
        for (int pr = 0; pr < 2; pr++) begin
          logic [3:0] oh, po;
          oh = 4'(1 << ch);
          po = 4'(1 << pr);
          mode_i = {4{2'(m)}};
          acquire(oh);
          unit_done_i = 1'b1; block_end_i = 1'b0; req_i = oh | po;
          cyc();
          chk(active_o === po && start_o === 1'b1, "R8 preempt", {start_o, active_o},
              {1'b1, po});
          unit_done_i = 1'b1; block_end_i = 1'b1; req_i = oh;
          cyc();
          chk(active_o === oh && start_o === 1'b1, "R11 resume", {start_o, active_o},
              {1'b1, oh});
          release_all();
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule